// File: doc/BRIEF.md
# Master-transmit frame sequencer for a two-wire serial bus

The block walks one master-transmit frame, field by field, over a bit-slot interface. After a start request it captures the frame header (broadcast flag, 12-bit own address, 12-bit target address, 4-bit control code, 8-bit byte count). It then drives, one bit slot at a time, a start bit, the broadcast bit, the address, control and length fields and the data bytes. Each field from the own address onward is followed by an even parity bit. Every field after the own address also gets an acknowledge slot. Bit-level line coding and arbitration are handled elsewhere. A slot generator pulses `slot_stb` at the end of every bit slot and returns the level sampled on the line and a timing-violation flag for that slot.

Data bytes come from a one-byte holding register that the CPU fills. When the sequencer copies a byte, it pulses `data_take` and the data-set interrupt, so that the next byte can be written in time. Four error kinds end a frame at once: timing, parity readback, missing acknowledge and data underrun. On an error the engine drops back to idle, records a status code and issues no further interrupts for that frame. A frame whose length field asks for more than 32 bytes is cut after byte 32 and ends with an end-of-frame pulse. A frame that fits ends with an end-of-communication pulse. The communication-start interrupt follows the own-address parity bit, but never sooner than a set number of cycles after the start was accepted.

States: `S_IDLE` (line released), `S_START` (start bit), `S_BCAST` (broadcast bit), `S_BITS` (field bits, MSB first), `S_PAR` (parity bit), `S_ACK` (acknowledge slot). The transitions are as follows:
- `S_IDLE→S_START` on an accepted start request.
- `S_START→S_BCAST→S_BITS` on strobes, with the own address loaded on entry to `S_BITS`.
- `S_BITS→S_PAR` after the last field bit.
- `S_PAR→S_BITS` after the own address, with the target address loaded.
- `S_PAR→S_ACK` for every other field.
- `S_ACK→S_BITS` when the next field or data byte is loaded.
- `S_ACK→S_IDLE` at end of communication or end of frame.
- Any active state→`S_IDLE` on an error.

Top module: `mfs_master_seq`

## Requirements
- R1: After reset, and while idle, `tx_bit` is 1, `status` is 0 and every interrupt and error output is 0.
- R2: The slots after an accepted start carry, on `tx_bit`, in this order:
  - a start bit of 0;
  - the broadcast flag;
  - the 12-bit own address;
  - the 12-bit target address;
  - the 4-bit control code;
  - the 8-bit length;
  - then the data bytes.
  Every field is sent MSB first.
- R3: A parity bit follows the own address, target address, control, length and every data byte, and it makes the field's count of ones even. If the level sampled in a parity slot differs from the parity bit, the block pulses `err_parity` and writes status code 2.
- R4: An acknowledge slot, in which `tx_bit` is 1, follows the parity bit of the target address, control, length and each data byte, but not of the own address. If `rx_bit` is 1 in such a slot of a non-broadcast frame, the block pulses `err_ack` and writes status code 3. In broadcast frames the sampled level is ignored.
- R5: A strobe with `slot_terr` high in any active state pulses `err_timing` and writes status code 1.
- R6: If `data_vld` is low at the strobe where the first bit of the next data byte must be driven, the block pulses `err_underrun` and writes status code 4.
- R7: Each data byte is copied from `data_in` at that strobe. The block then pulses `irq_dset` and `data_take` once per byte.
- R8: When the number of bytes sent equals the length field (0 to 32), the block pulses `irq_eoc` after the last acknowledge slot, or after the length field's acknowledge slot when the length is 0.
- R9: When the length field exceeds 32, the frame ends after the 32nd byte's acknowledge slot with a pulse on `irq_eof` and no `irq_eoc`.
- R10: Every interrupt and error output is a one-cycle pulse. After any error the block is idle, and no further interrupt or error occurs in that frame. `status` keeps its code until the next accepted start, which clears it to 0.
- R11: `irq_start` pulses once after the own-address parity slot passes, no earlier than `START_GAP` cycles after the start was accepted. It is not issued if the frame ends first.
- R12: A start request while a frame is active has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_req | input | 1 | start request, accepted only when idle |
| hdr_bcast | input | 1 | 1 = broadcast frame |
| hdr_maddr | input | MA_W | own address |
| hdr_saddr | input | SA_W | target address |
| hdr_ctrl | input | CT_W | control code |
| hdr_len | input | LEN_W | requested data byte count |
| data_in | input | DAT_W | holding register content |
| data_vld | input | 1 | holding register is full |
| data_take | output | 1 | pulse: holding register was copied |
| slot_stb | input | 1 | end of a bit slot |
| rx_bit | input | 1 | line level sampled in the slot |
| slot_terr | input | 1 | timing violation in the slot |
| tx_bit | output | 1 | level to drive in the current slot |
| irq_start | output | 1 | communication-start interrupt pulse |
| irq_dset | output | 1 | data-set interrupt pulse |
| irq_eoc | output | 1 | end-of-communication pulse |
| irq_eof | output | 1 | end-of-frame pulse |
| err_timing | output | 1 | timing error pulse |
| err_parity | output | 1 | parity error pulse |
| err_ack | output | 1 | acknowledge error pulse |
| err_underrun | output | 1 | underrun error pulse |
| status | output | 3 | last error code (0 none) |

## Verification
The assertions assume that `slot_stb` is a single-cycle pulse with at least one quiet cycle between strobes. They also assume that `data_vld` does not change in the strobe cycle, and that reset lasts more than one clock. The bench drives strobes every eight cycles and changes the holding register only on the cycle after `data_take`. It injects at most one fault per frame, placed on a slot of the matching kind (parity or acknowledge) or, for a timing fault, on any slot. It keeps faults out of the window in which the start interrupt's delay expires, so the expected presence of `irq_start` stays exact.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_BCAST, S_BITS, S_PAR, S_ACK
    } seq_state_t;

    typedef enum logic [2:0] {
        F_MADDR, F_SADDR, F_CTRL, F_TLEN, F_DATA
    } field_t;

    typedef enum logic [3:0] {
        EV_NONE, EV_TERR, EV_PERR, EV_AERR, EV_UNDER, EV_EOC, EV_EOF, EV_DSET
    } seq_event_t;

    localparam logic [2:0] ST_NONE   = 3'd0;
    localparam logic [2:0] ST_TIMING = 3'd1;
    localparam logic [2:0] ST_PARITY = 3'd2;
    localparam logic [2:0] ST_ACK    = 3'd3;
    localparam logic [2:0] ST_UNDER  = 3'd4;
endpackage

// File: rtl/mfs_field_shift.sv
module mfs_field_shift #(
    parameter int W  = 12,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic [LW-1:0] load_len,
    input  logic          shift,
    output logic          bit_o,
    output logic          par_o
);
    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            par_o <= 1'b0;
        end else if (load) begin
            sr    <= load_val << (LW'(W) - load_len);
            par_o <= ^load_val;
        end else if (shift) begin
            sr    <= {sr[W-2:0], 1'b0};
        end
    end

    assign bit_o = sr[W-1];
endmodule

// File: rtl/mfs_gap_timer.sv
module mfs_gap_timer #(
    parameter int GAP = 8280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic arm,
    input  logic abort,
    output logic irq_start
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] elapsed;
    logic          pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed   <= '0;
            pend      <= 1'b0;
            irq_start <= 1'b0;
        end else begin
            irq_start <= 1'b0;
            if (restart) begin
                elapsed <= '0;
                pend    <= 1'b0;
            end else begin
                if (elapsed < CW'(GAP)) elapsed <= elapsed + CW'(1);
                if (abort) begin
                    pend <= 1'b0;
                end else if (arm) begin
                    pend <= 1'b1;
                end else if (pend && elapsed >= CW'(GAP)) begin
                    pend      <= 1'b0;
                    irq_start <= 1'b1;
                end
            end
        end
    end

    AST_START_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> (elapsed >= CW'(GAP)));                     // R11
    AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> !pend);                                      // R11
endmodule

// File: rtl/mfs_ctrl.sv
module mfs_ctrl
    import mfs_pkg::*;
#(
    parameter int MA_W      = 12,
    parameter int SA_W      = 12,
    parameter int CT_W      = 4,
    parameter int LEN_W     = 8,
    parameter int DAT_W     = 8,
    parameter int MAX_BYTES = 32,
    parameter int FW        = 12,
    parameter int LW        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             hdr_bcast,
    input  logic [MA_W-1:0]  hdr_maddr,
    input  logic [SA_W-1:0]  hdr_saddr,
    input  logic [CT_W-1:0]  hdr_ctrl,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [DAT_W-1:0] data_in,
    input  logic             data_vld,
    input  logic             slot_stb,
    input  logic             rx_bit,
    input  logic             slot_terr,
    input  logic             sh_bit,
    input  logic             sh_par,
    output logic             sh_load,
    output logic [FW-1:0]    sh_val,
    output logic [LW-1:0]    sh_len,
    output logic             sh_shift,
    output logic             accept,
    output logic             arm,
    output logic             abort,
    output logic             tx_bit,
    output logic             data_take,
    output logic             irq_dset,
    output logic             irq_eoc,
    output logic             irq_eof,
    output logic             err_timing,
    output logic             err_parity,
    output logic             err_ack,
    output logic             err_underrun,
    output logic [2:0]       status
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    seq_state_t       state, state_n;
    field_t           field, field_n;
    seq_event_t       ev;
    logic [LW-1:0]    bits_left;
    logic [CNT_W-1:0] byte_cnt;
    logic             bcast_q, try_byte;
    logic [MA_W-1:0]  ma_q;
    logic [SA_W-1:0]  sa_q;
    logic [CT_W-1:0]  ct_q;
    logic [LEN_W-1:0] tl_q;

    always_comb begin
        state_n  = state;
        field_n  = field;
        ev       = EV_NONE;
        sh_load  = 1'b0;
        sh_val   = '0;
        sh_len   = '0;
        sh_shift = 1'b0;
        arm      = 1'b0;
        try_byte = 1'b0;
        accept   = (state == S_IDLE) && start_req;
        if (accept) begin
            state_n = S_START;
        end else if (state != S_IDLE && slot_stb) begin
            if (slot_terr) begin
                ev      = EV_TERR;
                state_n = S_IDLE;
            end else begin
                unique case (state)
                    S_START: state_n = S_BCAST;
                    S_BCAST: begin
                        sh_load = 1'b1; sh_val = FW'(ma_q); sh_len = LW'(MA_W);
                        field_n = F_MADDR; state_n = S_BITS;
                    end
                    S_BITS: begin
                        if (bits_left == '0) state_n = S_PAR;
                        else                 sh_shift = 1'b1;
                    end
                    S_PAR: begin
                        if (rx_bit != sh_par) begin
                            ev = EV_PERR; state_n = S_IDLE;
                        end else if (field == F_MADDR) begin
                            arm     = 1'b1;
                            sh_load = 1'b1; sh_val = FW'(sa_q); sh_len = LW'(SA_W);
                            field_n = F_SADDR; state_n = S_BITS;
                        end else begin
                            state_n = S_ACK;
                        end
                    end
                    S_ACK: begin
                        if (!bcast_q && rx_bit) begin
                            ev = EV_AERR; state_n = S_IDLE;
                        end else begin
                            unique case (field)
                                F_SADDR: begin
                                    sh_load = 1'b1; sh_val = FW'(ct_q); sh_len = LW'(CT_W);
                                    field_n = F_CTRL; state_n = S_BITS;
                                end
                                F_CTRL: begin
                                    sh_load = 1'b1; sh_val = FW'(tl_q); sh_len = LW'(LEN_W);
                                    field_n = F_TLEN; state_n = S_BITS;
                                end
                                F_TLEN: begin
                                    if (tl_q == '0) begin ev = EV_EOC; state_n = S_IDLE; end
                                    else try_byte = 1'b1;
                                end
                                F_DATA: begin
                                    if (LEN_W'(byte_cnt) == tl_q) begin
                                        ev = EV_EOC; state_n = S_IDLE;
                                    end else if (byte_cnt == CNT_W'(MAX_BYTES)) begin
                                        ev = EV_EOF; state_n = S_IDLE;
                                    end else begin
                                        try_byte = 1'b1;
                                    end
                                end
                                default: state_n = S_IDLE;
                            endcase
                        end
                    end
                    default: state_n = S_IDLE;
                endcase
                if (try_byte) begin
                    if (!data_vld) begin
                        ev = EV_UNDER; state_n = S_IDLE;
                    end else begin
                        sh_load = 1'b1; sh_val = FW'(data_in); sh_len = LW'(DAT_W);
                        ev = EV_DSET; field_n = F_DATA; state_n = S_BITS;
                    end
                end
            end
        end
        abort = (state != S_IDLE) && (state_n == S_IDLE);
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            field     <= F_MADDR;
            bits_left <= '0;
            byte_cnt  <= '0;
            bcast_q   <= 1'b0;
            ma_q      <= '0;
            sa_q      <= '0;
            ct_q      <= '0;
            tl_q      <= '0;
        end else begin
            state <= state_n;
            field <= field_n;
            if (accept) begin
                bcast_q  <= hdr_bcast;
                ma_q     <= hdr_maddr;
                sa_q     <= hdr_saddr;
                ct_q     <= hdr_ctrl;
                tl_q     <= hdr_len;
                byte_cnt <= '0;
            end
            if (sh_load)       bits_left <= sh_len - LW'(1);
            else if (sh_shift) bits_left <= bits_left - LW'(1);
            if (ev == EV_DSET) byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end

    // registered pulse outputs and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_take <= 1'b0; irq_dset <= 1'b0; irq_eoc <= 1'b0; irq_eof <= 1'b0;
            err_timing <= 1'b0; err_parity <= 1'b0; err_ack <= 1'b0; err_underrun <= 1'b0;
            status <= ST_NONE;
        end else begin
            data_take    <= (ev == EV_DSET);
            irq_dset     <= (ev == EV_DSET);
            irq_eoc      <= (ev == EV_EOC);
            irq_eof      <= (ev == EV_EOF);
            err_timing   <= (ev == EV_TERR);
            err_parity   <= (ev == EV_PERR);
            err_ack      <= (ev == EV_AERR);
            err_underrun <= (ev == EV_UNDER);
            if (accept) begin
                status <= ST_NONE;
            end else begin
                unique case (ev)
                    EV_TERR:  status <= ST_TIMING;
                    EV_PERR:  status <= ST_PARITY;
                    EV_AERR:  status <= ST_ACK;
                    EV_UNDER: status <= ST_UNDER;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            S_START: tx_bit = 1'b0;
            S_BCAST: tx_bit = bcast_q;
            S_BITS:  tx_bit = sh_bit;
            S_PAR:   tx_bit = sh_par;
            default: tx_bit = 1'b1;
        endcase
    end

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timing || err_parity || err_ack || err_underrun) |-> (state == S_IDLE)); // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_IDLE) |->
        !(irq_dset || irq_eoc || irq_eof || err_timing || err_parity || err_ack || err_underrun)); // R10
    AST_DSET_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dset |-> $past(data_vld));                              // R7
    AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(MAX_BYTES));                             // R9
    AST_EOF_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eof |-> (byte_cnt == CNT_W'(MAX_BYTES)));               // R9
    AST_EOC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoc |-> (LEN_W'(byte_cnt) == tl_q));                    // R8
endmodule

// File: rtl/mfs_master_seq.sv
module mfs_master_seq #(
    parameter int MA_W      = 12,
    parameter int SA_W      = 12,
    parameter int CT_W      = 4,
    parameter int LEN_W     = 8,
    parameter int DAT_W     = 8,
    parameter int MAX_BYTES = 32,
    parameter int START_GAP = 8280
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             hdr_bcast,
    input  logic [MA_W-1:0]  hdr_maddr,
    input  logic [SA_W-1:0]  hdr_saddr,
    input  logic [CT_W-1:0]  hdr_ctrl,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [DAT_W-1:0] data_in,
    input  logic             data_vld,
    output logic             data_take,
    input  logic             slot_stb,
    input  logic             rx_bit,
    input  logic             slot_terr,
    output logic             tx_bit,
    output logic             irq_start,
    output logic             irq_dset,
    output logic             irq_eoc,
    output logic             irq_eof,
    output logic             err_timing,
    output logic             err_parity,
    output logic             err_ack,
    output logic             err_underrun,
    output logic [2:0]       status
);
    localparam int FW = (MA_W > SA_W) ? MA_W : SA_W;
    localparam int LW = $clog2(FW + 1);

    logic          sh_load, sh_shift, sh_bit, sh_par, accept, arm, abort;
    logic [FW-1:0] sh_val;
    logic [LW-1:0] sh_len;

    mfs_ctrl #(
        .MA_W(MA_W), .SA_W(SA_W), .CT_W(CT_W), .LEN_W(LEN_W), .DAT_W(DAT_W),
        .MAX_BYTES(MAX_BYTES), .FW(FW), .LW(LW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .hdr_bcast(hdr_bcast), .hdr_maddr(hdr_maddr), .hdr_saddr(hdr_saddr),
        .hdr_ctrl(hdr_ctrl), .hdr_len(hdr_len),
        .data_in(data_in), .data_vld(data_vld),
        .slot_stb(slot_stb), .rx_bit(rx_bit), .slot_terr(slot_terr),
        .sh_bit(sh_bit), .sh_par(sh_par),
        .sh_load(sh_load), .sh_val(sh_val), .sh_len(sh_len), .sh_shift(sh_shift),
        .accept(accept), .arm(arm), .abort(abort),
        .tx_bit(tx_bit), .data_take(data_take), .irq_dset(irq_dset),
        .irq_eoc(irq_eoc), .irq_eof(irq_eof),
        .err_timing(err_timing), .err_parity(err_parity),
        .err_ack(err_ack), .err_underrun(err_underrun), .status(status)
    );

    mfs_field_shift #(.W(FW), .LW(LW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
        .load_len(sh_len), .shift(sh_shift), .bit_o(sh_bit), .par_o(sh_par)
    );

    mfs_gap_timer #(.GAP(START_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .restart(accept), .arm(arm),
        .abort(abort), .irq_start(irq_start)
    );
endmodule

// File: tb/tb_mfs_master_seq.sv
module tb_mfs_master_seq;
    localparam int CLK_PER  = 10;
    localparam int SLOT_CYC = 8;
    localparam int GAP      = 150;

    logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0;
    logic hdr_bcast = 1'b0;
    logic [11:0] hdr_maddr = '0, hdr_saddr = '0;
    logic [3:0]  hdr_ctrl = '0;
    logic [7:0]  hdr_len = '0;
    logic [7:0]  data_in;
    logic data_vld, data_take;
    logic slot_stb = 1'b0, rx_bit = 1'b1, slot_terr = 1'b0;
    logic tx_bit, irq_start, irq_dset, irq_eoc, irq_eof;
    logic err_timing, err_parity, err_ack, err_underrun;
    logic [2:0] status;

    mfs_master_seq #(.START_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .hdr_bcast(hdr_bcast),
        .hdr_maddr(hdr_maddr), .hdr_saddr(hdr_saddr), .hdr_ctrl(hdr_ctrl),
        .hdr_len(hdr_len), .data_in(data_in), .data_vld(data_vld),
        .data_take(data_take), .slot_stb(slot_stb), .rx_bit(rx_bit),
        .slot_terr(slot_terr), .tx_bit(tx_bit), .irq_start(irq_start),
        .irq_dset(irq_dset), .irq_eoc(irq_eoc), .irq_eof(irq_eof),
        .err_timing(err_timing), .err_parity(err_parity), .err_ack(err_ack),
        .err_underrun(err_underrun), .status(status)
    );

    always #(CLK_PER/2) clk = ~clk;

    int n_checks = 0, n_err = 0;
    int cyc = 0, c_take = 0, c_dset = 0, c_eoc = 0, c_eof = 0;
    int c_te = 0, c_pe = 0, c_ae = 0, c_ue = 0, c_st = 0, st_cyc = 0;
    int take_base = 0, avail = 0, fseed = 0;
    logic h_b;
    logic [11:0] h_ma, h_sa;
    logic [3:0] h_ct;
    logic [7:0] h_tl;

    function automatic logic [7:0] byte_of(input int j);
        return 8'(j * 37 + fseed * 11 + 5);
    endfunction

    assign data_vld = ((c_take - take_base) < avail);
    assign data_in  = byte_of(c_take - take_base);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (data_take) c_take <= c_take + 1;
        if (irq_dset) c_dset <= c_dset + 1;
        if (irq_eoc) c_eoc <= c_eoc + 1;
        if (irq_eof) c_eof <= c_eof + 1;
        if (err_timing) c_te <= c_te + 1;
        if (err_parity) c_pe <= c_pe + 1;
        if (err_ack) c_ae <= c_ae + 1;
        if (err_underrun) c_ue <= c_ue + 1;
        if (irq_start) begin c_st <= c_st + 1; st_cyc <= cyc; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected line level of slot s (layout fixed by R2, R3, R4)
    function automatic logic exp_bit(input int s);
        int j, p;
        logic [7:0] d;
        if (s == 0) return 1'b0;
        if (s == 1) return h_b;
        if (s <= 13) return h_ma[11-(s-2)];
        if (s == 14) return ^h_ma;
        if (s <= 26) return h_sa[11-(s-15)];
        if (s == 27) return ^h_sa;
        if (s == 28) return 1'b1;
        if (s <= 32) return h_ct[3-(s-29)];
        if (s == 33) return ^h_ct;
        if (s == 34) return 1'b1;
        if (s <= 42) return h_tl[7-(s-35)];
        if (s == 43) return ^h_tl;
        if (s == 44) return 1'b1;
        j = (s - 45) / 10; p = (s - 45) % 10; d = byte_of(j);
        if (p < 8) return d[7-p];
        if (p == 8) return ^d;
        return 1'b1;
    endfunction

    function automatic bit is_ack(input int s);
        return (s == 28 || s == 34 || s == 44 || (s > 44 && (s - 45) % 10 == 9));
    endfunction

    // ikind: 0 none, 1 timing, 2 parity readback, 3 ack; underrun comes from av < length
    task automatic run_frame(input logic b, input logic [11:0] ma, input logic [11:0] sa,
                             input logic [3:0] ct, input logic [7:0] tl, input int av,
                             input int ikind, input int islot, input int seed, input bit mid);
        int n, last, und, end_s, code, exp_ds, b_take, b_dset, b_eoc, b_eof;
        int b_te, b_pe, b_ae, b_ue, b_st, s_cyc, mism;
        logic e, r;
        h_b = b; h_ma = ma; h_sa = sa; h_ct = ct; h_tl = tl; fseed = seed;
        n = (tl > 32) ? 32 : int'(tl);
        last = 44 + 10 * n;
        und = (av < n) ? 44 + 10 * av : 100000;
        end_s = last; code = 0;
        if (und <= end_s) begin end_s = und; code = 4; end
        if (ikind != 0 && islot <= end_s) begin end_s = islot; code = ikind; end
        exp_ds = 0;
        for (int j = 0; j < n && j < av; j++) if (44 + 10 * j < end_s) exp_ds++;
        @(negedge clk);
        take_base = c_take; avail = av;
        b_take = c_take; b_dset = c_dset; b_eoc = c_eoc; b_eof = c_eof;
        b_te = c_te; b_pe = c_pe; b_ae = c_ae; b_ue = c_ue; b_st = c_st;
        hdr_bcast = b; hdr_maddr = ma; hdr_saddr = sa; hdr_ctrl = ct; hdr_len = tl;
        start_req = 1'b1; s_cyc = cyc;
        @(negedge clk);
        start_req = 1'b0;
        mism = 0;
        for (int s = 0; s <= end_s + 4; s++) begin
            repeat (SLOT_CYC - 1) @(negedge clk);
            e = exp_bit(s);
            if (s <= end_s && tx_bit !== e) mism++;
            r = e;
            if (is_ack(s)) r = b;
            if (ikind == 2 && s == islot) r = ~e;
            if (ikind == 3 && s == islot) r = 1'b1;
            rx_bit = r;
            slot_terr = (ikind == 1 && s == islot);
            start_req = mid && (s == 30);
            slot_stb = 1'b1;
            @(negedge clk);
            slot_stb = 1'b0; slot_terr = 1'b0; start_req = 1'b0; rx_bit = 1'b1;
        end
        repeat (3) @(negedge clk);
        chk(mism == 0, mid ? "R12 tx sequence with mid-frame start" : "R2 tx sequence", mism, 0);
        chk(c_dset - b_dset == exp_ds, "R7 dset count", c_dset - b_dset, exp_ds);
        chk(c_take - b_take == exp_ds, "R7 take count", c_take - b_take, exp_ds);
        chk(c_eoc - b_eoc == ((code == 0 && tl <= 32) ? 1 : 0), "R8 eoc", c_eoc - b_eoc,
            (code == 0 && tl <= 32) ? 1 : 0);
        chk(c_eof - b_eof == ((code == 0 && tl > 32) ? 1 : 0), "R9 eof", c_eof - b_eof,
            (code == 0 && tl > 32) ? 1 : 0);
        chk(c_te - b_te == (code == 1 ? 1 : 0), "R5 timing error", c_te - b_te, code == 1 ? 1 : 0);
        chk(c_pe - b_pe == (code == 2 ? 1 : 0), "R3 parity error", c_pe - b_pe, code == 2 ? 1 : 0);
        chk(c_ae - b_ae == (code == 3 ? 1 : 0), "R4 ack error", c_ae - b_ae, code == 3 ? 1 : 0);
        chk(c_ue - b_ue == (code == 4 ? 1 : 0), "R6 underrun", c_ue - b_ue, code == 4 ? 1 : 0);
        chk(int'(status) == code, "R10 status code", int'(status), code);
        chk(tx_bit === 1'b1, "R1 idle line after frame", int'(tx_bit), 1);
        if (end_s > 20) begin
            chk(c_st - b_st == 1, "R11 start irq issued", c_st - b_st, 1);
            chk(st_cyc - s_cyc >= GAP, "R11 start irq spacing", st_cyc - s_cyc, GAP);
        end else if (end_s < 15) begin
            chk(c_st - b_st == 0, "R11 start irq suppressed", c_st - b_st, 0);
        end
    endtask

    initial begin
        #(CLK_PER * 20000 * 10);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int ik, isl, tl, av, n, r;
        logic b;
        void'($urandom(32'h1eb5));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_bit === 1'b1, "R1 reset tx_bit", int'(tx_bit), 1);
        chk(status == 3'd0, "R1 reset status", int'(status), 0);
        chk({irq_start, irq_dset, irq_eoc, irq_eof, err_timing, err_parity, err_ack, err_underrun} == 8'h0,
            "R1 reset pulses", 0, 0);

        run_frame(1'b0, 12'hA5C, 12'h3F1, 4'h9, 8'd3, 3, 0, 0, 1, 1'b0);
        run_frame(1'b0, 12'h001, 12'hFFE, 4'h0, 8'd0, 0, 0, 0, 2, 1'b0);   // R8 zero length
        run_frame(1'b0, 12'h7B2, 12'h456, 4'hF, 8'd32, 32, 0, 0, 3, 1'b0); // R8 exactly 32
        run_frame(1'b0, 12'h135, 12'h9AC, 4'h6, 8'd40, 40, 0, 0, 4, 1'b0); // R9 cut at 32
        run_frame(1'b1, 12'hC3C, 12'h0F0, 4'h3, 8'd2, 2, 0, 0, 5, 1'b0);   // R4 broadcast ignores ack
        run_frame(1'b0, 12'h222, 12'h444, 4'h1, 8'd4, 4, 3, 34, 6, 1'b0);  // R4 ack error
        run_frame(1'b0, 12'h8E1, 12'h111, 4'h2, 8'd4, 4, 2, 14, 7, 1'b0);  // R3 own-address parity
        run_frame(1'b0, 12'h5A5, 12'h333, 4'h4, 8'd6, 6, 1, 60, 8, 1'b0);  // R5 timing
        run_frame(1'b0, 12'h6C6, 12'h777, 4'h5, 8'd5, 2, 0, 0, 9, 1'b0);   // R6 underrun
        run_frame(1'b0, 12'h0AA, 12'h055, 4'h7, 8'd2, 2, 0, 0, 10, 1'b1);  // R12 ignored start

        for (int k = 0; k < 10; k++) begin
            ik = int'($urandom % 5);
            tl = int'($urandom % 45);
            n = (tl > 32) ? 32 : tl;
            b = (ik == 3) ? 1'b0 : 1'($urandom % 2);
            av = tl; isl = 0;
            if (ik == 4) begin
                if (n > 0) av = int'($urandom % n);
                ik = 0;
            end else if (ik == 1) begin
                isl = int'($urandom % (45 + 10 * n));
                if (isl >= 15 && isl <= 20) isl = 21;
            end else if (ik == 2) begin
                r = int'($urandom % (4 + n));
                isl = (r == 0) ? 14 : (r == 1) ? 27 : (r == 2) ? 33 : (r == 3) ? 43 : 53 + 10 * (r - 4);
            end else if (ik == 3) begin
                r = int'($urandom % (3 + n));
                isl = (r == 0) ? 28 : (r == 1) ? 34 : (r == 2) ? 44 : 54 + 10 * (r - 3);
            end
            run_frame(b, 12'($urandom), 12'($urandom), 4'($urandom), 8'(tl), av, ik, isl, 20 + k, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule